// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts down a programmable 16-bit timeout, one count per 2^N pulses of a slow tick enable. Each tick arrives as a one-cycle strobe from a 32 kHz time base. Software restarts the countdown by writing the timeout register. If software fails to restart it, the first expiry performs a programmable first action. The counter then reloads for a second period. A second expiry performs a separately programmed second action, and the watchdog then stays halted until the next restart.

Each stage has its own action code: nothing, a maskable interrupt, a system-management interrupt, or a system reset. Sticky status flags record the expiry and each action that fired. The two interrupt outputs follow their flags as levels. The reset output is a one-cycle pulse. Software reaches three 16-bit registers over a simple byte-addressed read/write bus: configuration at 0x0, timeout at 0x2 and status at 0x6.

Top module: `wdt_two_stage`

## Requirements
- R1: After the synchronous reset, the configuration, timeout and status registers all read 0, all three action outputs are low, and no expiry occurs until the timeout register is written.
- R2: A write to the timeout register (0x2) loads that value as the reload value and restarts stage 1 from a full count with a cleared prescaler. Repeated writes before expiry prevent any expiry. The value written reads back unchanged.
- R3: Configuration bits 3:0 hold N. One count is taken every 2^N enabled ticks, so stage 1 expires after timeout×2^N ticks. Codes 14 and 15 behave as 13.
- R4: While configuration bit 8 is 1, ticks are ignored and the countdown holds. Clearing the bit resumes counting.
- R5: On stage-1 expiry the counter reloads and stage 2 runs for the same length. After the stage-2 expiry no further expiry occurs, whatever ticks arrive, until the next timeout write.
- R6: Configuration bits 5:4 give the stage-1 action and bits 7:6 the stage-2 action: 00 none, 01 interrupt (status bit 1), 10 system-management interrupt (status bit 2), 11 reset (status bit 3). Code 00 sets no action flag.
- R7: Status bit 0 sets on every expiry. A status write with bit 0 = 1 clears bit 0 only.
- R8: Status bits 3:1 clear only through reset or a status write with bit 0 = 0. A status write with bit 0 = 1 leaves them set.
- R9: irq_o equals status bit 1 and smi_o equals status bit 2. rst_req_o is high for exactly the one cycle after each expiry whose action is reset.
- R10: Configuration bits 15:9 and status bits 7:4 always read 0, whatever value is written to them.
- R11: Writing a timeout of 0 stops the watchdog: no expiry and no action occur until a nonzero value is written.
- R12: bus_rdata carries the addressed register in the cycle after a read strobe and reads 0 in all other cycles. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle slow time-base strobe |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt level |
| smi_o | output | 1 | System-management interrupt level |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
A register write takes effect at the clock edge that samples it. The expiry decision is taken at the edge that samples the terminal tick. Flags, irq_o, smi_o and the rst_req_o pulse change at that same edge, so they are visible from the following cycle. Read data appears one edge after the strobe. The bench drives stimulus on falling edges and advances a behavioural model on each rising edge. On the falling edge after that, it compares every output with the model. Directed checks count the ticks up to each action and read the registers back exactly one cycle after each strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_TOUT = 2;
  localparam int ADDR_STAT = 6;

  localparam int GATE_BIT  = 8;
  localparam int CFG_LIVE  = 9;   // bits below this index are writable

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_IRQ  = 2'b01,
    ACT_SMI  = 2'b10,
    ACT_RST  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } stage_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEL_W   = 4,
  parameter int SEL_MAX = 13,
  localparam int CW     = (SEL_MAX > 0) ? SEL_MAX : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_tick_o
);
  logic [CW-1:0]    pcnt;
  logic [CW-1:0]    mask;
  logic [SEL_W-1:0] sel_eff;
  logic             step;
  logic             term;

  // reserved codes above the maximum fall back to the maximum
  always_comb begin
    sel_eff = (sel_i > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel_i;
    mask    = '0;
    for (int i = 0; i < CW; i++) begin
      if (i < int'(sel_eff)) mask[i] = 1'b1;
    end
  end

  assign step       = tick_i & en_i;
  assign term       = (pcnt >= mask);
  assign div_tick_o = step & term;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pcnt <= '0;
    end else if (step) begin
      pcnt <= term ? '0 : pcnt + 1'b1;
    end
  end

  AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pcnt == '0)) else $error("prescaler not cleared on kick"); // R2
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kick_i,
  input  logic [TW-1:0] kick_val_i,
  input  logic [TW-1:0] reload_i,
  input  logic          div_tick_i,
  output logic          exp_o,
  output logic          exp_stage2_o
);
  stage_e        stage;
  logic [TW-1:0] cnt;
  logic          active;
  logic          last;

  assign active       = (stage != ST_IDLE);
  assign last         = (cnt == TW'(1));
  assign exp_o        = div_tick_i & ~kick_i & active & last;
  assign exp_stage2_o = (stage == ST_TWO);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_IDLE;
      cnt   <= '0;
    end else if (kick_i) begin
      cnt   <= kick_val_i;
      stage <= (kick_val_i == '0) ? ST_IDLE : ST_ONE;
    end else if (div_tick_i && active) begin
      if (last) begin
        if (stage == ST_ONE) begin
          cnt   <= reload_i;
          stage <= (reload_i == '0) ? ST_IDLE : ST_TWO;
        end else begin
          stage <= ST_IDLE;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_KICK_LOADS: assert property (@(posedge clk) disable iff (rst)
    (kick_i && kick_val_i != '0) |=> (stage == ST_ONE && cnt == $past(kick_val_i)))
    else $error("kick did not restart stage one"); // R2
  AST_HALT_AFTER_TWO: assert property (@(posedge clk) disable iff (rst)
    (exp_o && stage == ST_TWO) |=> (stage == ST_IDLE))
    else $error("stage two expiry did not halt"); // R5
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (rst)
    (kick_i && kick_val_i == '0) |=> (stage == ST_IDLE))
    else $error("zero timeout left counter running"); // R11
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic             bus_rd_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             exp_i,
  input  logic             exp_stage2_i,
  output logic             kick_o,
  output logic [DW-1:0]    timeout_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             gate_o,
  output logic             irq_o,
  output logic             smi_o,
  output logic             rst_req_o
);
  logic [DW-1:0] cfg_q;
  logic [7:0]    stat_q;
  logic [7:0]    stat_set;
  logic [7:0]    stat_clr;
  logic          cfg_wr;
  logic          stat_wr;
  act_e          act;

  assign cfg_wr  = bus_wr_i && (bus_addr_i == AW'(ADDR_CFG));
  assign kick_o  = bus_wr_i && (bus_addr_i == AW'(ADDR_TOUT));
  assign stat_wr = bus_wr_i && (bus_addr_i == AW'(ADDR_STAT));

  assign sel_o  = cfg_q[SEL_W-1:0];
  assign gate_o = cfg_q[GATE_BIT];
  assign irq_o  = stat_q[1];
  assign smi_o  = stat_q[2];

  always_comb begin
    act      = exp_stage2_i ? act_e'(cfg_q[7:6]) : act_e'(cfg_q[5:4]);
    stat_set = '0;
    if (exp_i) begin
      stat_set[0] = 1'b1;
      case (act)
        ACT_IRQ: stat_set[1] = 1'b1;
        ACT_SMI: stat_set[2] = 1'b1;
        ACT_RST: stat_set[3] = 1'b1;
        default: ;
      endcase
    end
    stat_clr = '0;
    if (stat_wr) stat_clr = bus_wdata_i[0] ? 8'h01 : 8'h0E;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      timeout_o <= '0;
      stat_q    <= '0;
      rst_req_o <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q[CFG_LIVE-1:0] <= bus_wdata_i[CFG_LIVE-1:0];
      if (kick_o) timeout_o <= bus_wdata_i;
      // a new event beats a clear in the same cycle
      stat_q[3:0] <= (stat_q[3:0] & ~stat_clr[3:0]) | stat_set[3:0];
      rst_req_o   <= exp_i && (act == ACT_RST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      case (int'(bus_addr_i))
        ADDR_CFG:  bus_rdata_o <= cfg_q;
        ADDR_TOUT: bus_rdata_o <= timeout_o;
        ADDR_STAT: bus_rdata_o <= {{(DW-8){1'b0}}, stat_q};
        default:   bus_rdata_o <= '0;
      endcase
    end else begin
      bus_rdata_o <= '0;
    end
  end

  AST_OVF_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    exp_i |=> stat_q[0]) else $error("expiry did not set overflow"); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(stat_wr && !bus_wdata_i[0]))
    else $error("interrupt flag cleared without clear write"); // R8
  AST_RST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(exp_i)) else $error("reset pulse without expiry"); // R9
  AST_RSVD_CFG: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (cfg_q[DW-1:CFG_LIVE] == '0)) else $error("reserved bits changed"); // R10
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int SEL_W   = 4,
  parameter int SEL_MAX = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          smi_o,
  output logic          rst_req_o
);
  logic             kick;
  logic [DW-1:0]    timeout;
  logic [SEL_W-1:0] sel;
  logic             gate;
  logic             div_tick;
  logic             exp;
  logic             exp_stage2;

  wdt_regs #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .bus_addr_i   (bus_addr),
    .bus_wr_i     (bus_wr),
    .bus_wdata_i  (bus_wdata),
    .bus_rd_i     (bus_rd),
    .bus_rdata_o  (bus_rdata),
    .exp_i        (exp),
    .exp_stage2_i (exp_stage2),
    .kick_o       (kick),
    .timeout_o    (timeout),
    .sel_o        (sel),
    .gate_o       (gate),
    .irq_o        (irq_o),
    .smi_o        (smi_o),
    .rst_req_o    (rst_req_o)
  );

  wdt_prescaler #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_pres (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (kick),
    .tick_i     (tick_i),
    .en_i       (~gate),
    .sel_i      (sel),
    .div_tick_o (div_tick)
  );

  wdt_countdown #(.TW(DW)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .kick_i       (kick),
    .kick_val_i   (bus_wdata),
    .reload_i     (timeout),
    .div_tick_i   (div_tick),
    .exp_o        (exp),
    .exp_stage2_o (exp_stage2)
  );
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, smi, rreq;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_two_stage u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata),
    .irq_o(irq), .smi_o(smi), .rst_req_o(rreq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_cfg, m_to, m_rdata;
  logic [7:0]  m_stat, m_set, m_clr;
  int          m_stage, m_el, m_n, m_code;
  bit          m_ex, m_two, m_pulse;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_to = 0; m_stat = 0; m_stage = 0; m_el = 0;
      m_rdata = 0; m_pulse = 0;
    end else begin
      m_rdata = 0;
      if (rd) begin
        if (addr == 0) m_rdata = m_cfg;
        else if (addr == 2) m_rdata = m_to;
        else if (addr == 6) m_rdata = {8'h00, m_stat};
      end
      m_ex = 0; m_two = 0; m_code = 0;
      m_n = int'(m_cfg[3:0]); if (m_n > 13) m_n = 13;
      if (wr && addr == 2) begin
        m_to = wdata; m_el = 0; m_stage = (wdata == 0) ? 0 : 1;
      end else if (m_stage != 0 && tick && !m_cfg[8]) begin
        m_el++;
        if (m_el == int'(m_to) * (1 << m_n)) begin
          m_ex = 1; m_two = (m_stage == 2); m_el = 0;
          m_stage = (m_stage == 1) ? 2 : 0;
        end
      end
      m_set = 0;
      if (m_ex) begin
        m_code = m_two ? int'(m_cfg[7:6]) : int'(m_cfg[5:4]);
        m_set[0] = 1;
        if (m_code != 0) m_set[m_code] = 1;
      end
      m_clr = 0;
      if (wr && addr == 6) m_clr = wdata[0] ? 8'h01 : 8'h0E;
      m_pulse = m_ex && (m_code == 3);
      m_stat = (m_stat & ~m_clr) | m_set;
      if (wr && addr == 0) m_cfg[8:0] = wdata[8:0];
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 irq_o vs model", int'(irq), int'(m_stat[1]));
      chk("R9 smi_o vs model", int'(smi), int'(m_stat[2]));
      chk("R9 rst_req_o vs model", int'(rreq), int'(m_pulse));
      chk("R12 bus_rdata vs model", int'(rdata), int'(m_rdata));
      if (rreq) pulses++;
    end
  end

  task automatic cyc(input bit t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic bwr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic ticks_until(input int which, output int n);
    n = 0;
    do begin
      cyc(1'b1);
      n++;
    end while (!((which == 0 && irq) || (which == 1 && smi) || (which == 2 && rreq)) && n < 20000);
  endtask

  task automatic clear_all();
    bwr(4'h6, 16'h0001);
    bwr(4'h6, 16'h0000);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int n;
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    brd(4'h0, v); chk("R1 cfg after reset", int'(v), 0);
    brd(4'h2, v); chk("R1 timeout after reset", int'(v), 0);
    brd(4'h6, v); chk("R1 status after reset", int'(v), 0);
    for (int i = 0; i < 20; i++) cyc(1'b1);
    chk("R1 no action before kick", int'(irq | smi | rreq), 0);

    // R10 reserved config bits; stage1 irq, stage2 reset, N=0
    bwr(4'h0, 16'hFED0);
    brd(4'h0, v); chk("R10 cfg reserved bits", int'(v), 16'h00D0);

    // R5 R6 two stages
    bwr(4'h2, 16'd5);
    ticks_until(0, n); chk("R5 stage1 ticks", n, 5);
    brd(4'h6, v); chk("R6 status after irq stage", int'(v), 16'h0003);
    p0 = pulses;
    ticks_until(2, n); chk("R5 stage2 ticks", n, 5);
    cyc(1'b1); chk("R9 reset pulse one cycle", int'(rreq), 0);
    brd(4'h6, v); chk("R6 status after reset stage", int'(v), 16'h000B);
    for (int i = 0; i < 30; i++) cyc(1'b1);
    chk("R5 halted after stage2", pulses - p0, 1);

    // R7 R8 clear rules
    bwr(4'h6, 16'h0001);
    brd(4'h6, v); chk("R7 overflow cleared alone", int'(v), 16'h000A);
    chk("R8 irq survives ovf clear", int'(irq), 1);
    bwr(4'h6, 16'h00F0);
    brd(4'h6, v); chk("R10 status reserved, R8 flags cleared", int'(v), 0);
    chk("R8 irq cleared", int'(irq), 0);

    // R3 prescaler N=2, stage1 SMI, stage2 none
    bwr(4'h0, 16'h0022);
    bwr(4'h2, 16'd3);
    ticks_until(1, n); chk("R3 divide by 4", n, 12);
    for (int i = 0; i < 12; i++) cyc(1'b1);
    brd(4'h6, v); chk("R6 none action sets only ovf", int'(v), 16'h0005);
    clear_all();

    // R3 reserved code 15 acts as 13
    bwr(4'h0, 16'h001F);
    bwr(4'h2, 16'd1);
    ticks_until(0, n); chk("R3 code 15 clamps to 13", n, 8192);
    clear_all();

    // R4 tick gate
    bwr(4'h0, 16'h0110);
    bwr(4'h2, 16'd4);
    for (int i = 0; i < 50; i++) cyc(1'b1);
    brd(4'h6, v); chk("R4 gated no expiry", int'(v), 0);
    bwr(4'h0, 16'h0010);
    ticks_until(0, n); chk("R4 resumes after ungate", n, 4);
    clear_all();

    // R11 zero timeout
    bwr(4'h0, 16'h0030);
    p0 = pulses;
    bwr(4'h2, 16'd0);
    for (int i = 0; i < 100; i++) cyc(1'b1);
    brd(4'h6, v); chk("R11 zero timeout idle", int'(v), 0);
    chk("R11 no reset pulse", pulses - p0, 0);

    // R2 repeated kicks
    bwr(4'h0, 16'h0010);
    for (int k = 0; k < 10; k++) begin
      bwr(4'h2, 16'd6);
      for (int i = 0; i < 5; i++) cyc(1'b1);
    end
    brd(4'h6, v); chk("R2 kicks prevent expiry", int'(v), 0);
    brd(4'h2, v); chk("R2 timeout readback", int'(v), 6);

    // R12 unmapped and idle read
    brd(4'hE, v); chk("R12 unmapped reads zero", int'(v), 0);
    cyc(1'b0); chk("R12 zero without strobe", int'(rdata), 0);

    finish_run();
  end
endmodule